// File: doc/BRIEF.md
# Conditional Branch Next-PC Unit

This combinational block sits in the fetch path of a 32-bit single-cycle RISC core. Each cycle it receives the instruction word, the current program counter and the two source operand values. From these it decides where the next instruction comes from. A small decoder recognises the conditional-branch opcode and uses the 3-bit condition field to choose one operation of a shared ALU. The ALU reports whether the condition holds in bit 0 of its result word.

The next-PC adder adds one of two increments to the current PC. The first is the constant 4. The second is the branch displacement, which is assembled from scattered instruction bits and sign-extended. The displacement is chosen only when the decoder's branch flag and ALU result bit 0 are both high. For any other instruction the ALU performs an ordinary addition, and the PC still advances by 4.

Top module: `branch_next_pc`

## Requirements
- R1: `is_branch` is 1 exactly when `inst[6:0]` is 7'b1100011 and `inst[14:12]` is one of 000, 001, 100, 101, 110, 111. Condition codes 010 and 011, and every other opcode, leave it at 0.
- R2: Condition 000 sets result bit 0 when `src_a == src_b`. Condition 001 sets it when the two operands differ.
- R3: Condition 100 sets result bit 0 when `src_a < src_b` as two's-complement values. Condition 101 sets it when `src_a >= src_b` as two's-complement values.
- R4: Condition 110 sets result bit 0 when `src_a < src_b` as unsigned values. Condition 111 sets it when `src_a >= src_b` as unsigned values.
- R5: While `is_branch` is 1, bits 31:1 of `alu_res` are zero.
- R6: When `is_branch` and `alu_res[0]` are both 1, `next_pc = pc + sext({inst[31], inst[7], inst[30:25], inst[11:8], 1'b0})`. The 13-bit value is sign-extended from bit 12, and the addition wraps modulo 2^32, so negative offsets move the PC backward.
- R7: In every other case, `next_pc = pc + 4`, wrapping modulo 2^32.
- R8: When `is_branch` is 0, `alu_res = src_a + src_b`. An odd sum does not redirect the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst | input | 32 | Instruction word of the current cycle |
| pc | input | 32 | Address of the current instruction |
| src_a | input | 32 | Value of the first source register |
| src_b | input | 32 | Value of the second source register |
| is_branch | output | 1 | Decoder flag: valid conditional branch |
| alu_res | output | 32 | Shared ALU result; bit 0 is the branch condition |
| next_pc | output | 32 | Address of the next instruction |

## Verification
Two functions meet in the same cycle: the ALU's condition evaluation and the decoder's branch recognition. The PC is redirected only when both agree. The bench provokes the disagreeing cases by applying a non-branch opcode whose operands sum to an odd value, so result bit 0 is 1 without a branch. It also applies the reserved condition codes 010 and 011 with the branch opcode and equal operands. In each case it judges that `next_pc` is still `pc + 4`. Every table vector also checks that a true condition and the branch flag together select the sign-extended displacement, including backward targets and a target that wraps below address zero.

// File: rtl/branch_next_pc.sv
module branch_next_pc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] inst,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            is_branch,
  output logic [XLEN-1:0] alu_res,
  output logic [XLEN-1:0] next_pc
);

  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam int         OFF_W      = 13;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SLT, ALU_SLTU, ALU_EQ, ALU_NE, ALU_GE, ALU_GEU
  } alu_op_e;

  logic [2:0]      cond;
  logic            opc_hit;
  alu_op_e         op;
  logic [OFF_W-1:0] off13;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] step;
  logic            take;

  assign cond    = inst[14:12];
  assign opc_hit = (inst[6:0] == OPC_BRANCH);

  always_comb begin
    op        = ALU_ADD;
    is_branch = 1'b0;
    if (opc_hit) begin
      is_branch = 1'b1;
      unique case (cond)
        3'b000:  op = ALU_EQ;
        3'b001:  op = ALU_NE;
        3'b100:  op = ALU_SLT;
        3'b101:  op = ALU_GE;
        3'b110:  op = ALU_SLTU;
        3'b111:  op = ALU_GEU;
        default: is_branch = 1'b0;
      endcase
    end
  end

  always_comb begin
    alu_res = '0;
    unique case (op)
      ALU_SLT:  alu_res[0] = $signed(src_a) <  $signed(src_b);
      ALU_SLTU: alu_res[0] = src_a <  src_b;
      ALU_EQ:   alu_res[0] = src_a == src_b;
      ALU_NE:   alu_res[0] = src_a != src_b;
      ALU_GE:   alu_res[0] = $signed(src_a) >= $signed(src_b);
      ALU_GEU:  alu_res[0] = src_a >= src_b;
      default:  alu_res    = src_a + src_b;
    endcase
  end

  assign off13   = {inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
  assign offset  = {{(XLEN-OFF_W){off13[OFF_W-1]}}, off13};
  assign take    = is_branch & alu_res[0];
  assign step    = take ? offset : XLEN'(4);
  assign next_pc = pc + step;

  always_comb begin
    if (is_branch)
      p_branch_decode_r1: assert (opc_hit && cond[2:1] != 2'b01)
        else $error("branch flag on a non-branch encoding");
    if (is_branch && cond == 3'b000)
      p_equal_r2: assert (alu_res[0] == (src_a == src_b))
        else $error("equal condition wrong");
    if (is_branch && cond == 3'b101)
      p_signed_ge_r3: assert (alu_res[0] == !($signed(src_a) < $signed(src_b)))
        else $error("signed ge condition wrong");
    if (is_branch && cond == 3'b110)
      p_unsigned_lt_r4: assert (alu_res[0] == !(src_a >= src_b))
        else $error("unsigned lt condition wrong");
    if (is_branch)
      p_upper_zero_r5: assert (alu_res[XLEN-1:1] == '0)
        else $error("upper result bits set on branch");
    if (is_branch && alu_res[0])
      p_target_aligned_r6: assert (next_pc[0] == pc[0])
        else $error("branch target parity changed");
    if (!(is_branch && alu_res[0]))
      p_sequential_r7: assert (next_pc - pc == XLEN'(4))
        else $error("sequential step not 4");
  end

endmodule

// File: tb/branch_next_pc_bench.sv
module branch_next_pc_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] inst, pc, src_a, src_b;
  logic        is_branch;
  logic [31:0] alu_res, next_pc;

  branch_next_pc u_branch_next_pc (
    .inst(inst), .pc(pc), .src_a(src_a), .src_b(src_b),
    .is_branch(is_branch), .alu_res(alu_res), .next_pc(next_pc)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [2:0]  f3;
    logic [12:0] off;
    logic [31:0] a;
    logic [31:0] b;
    logic        tk;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{3'b000, 13'h0010, 32'd5,         32'd5,         1'b1},
    '{3'b000, 13'h0010, 32'd5,         32'd6,         1'b0},
    '{3'b001, 13'h0020, 32'd5,         32'd6,         1'b1},
    '{3'b001, 13'h0020, 32'd7,         32'd7,         1'b0},
    '{3'b100, 13'h1FF0, 32'h8000_0000, 32'd1,         1'b1},
    '{3'b100, 13'h1FF0, 32'd1,         32'h8000_0000, 1'b0},
    '{3'b101, 13'h0040, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0},
    '{3'b101, 13'h0040, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1},
    '{3'b101, 13'h1F80, 32'd3,         32'd3,         1'b1},
    '{3'b100, 13'h0008, 32'hFFFF_FFFF, 32'd0,         1'b1},
    '{3'b110, 13'h0008, 32'hFFFF_FFFF, 32'd0,         1'b0},
    '{3'b111, 13'h0100, 32'hFFFF_FFFF, 32'd0,         1'b1},
    '{3'b111, 13'h0100, 32'd0,         32'hFFFF_FFFF, 1'b0},
    '{3'b110, 13'h1000, 32'd0,         32'hFFFF_FFFF, 1'b1},
    '{3'b100, 13'h0010, 32'd5,         32'd5,         1'b0},
    '{3'b111, 13'h0FFE, 32'd4,         32'd4,         1'b1}
  };

  function automatic logic [31:0] mk_b(input logic [2:0] f3, input logic [12:0] off);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] sext13(input logic [12:0] off);
    return {{19{off[12]}}, off};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    inst = i; pc = p; src_a = a; src_b = b;
    #2;
  endtask

  initial begin
    inst = '0; pc = '0; src_a = '0; src_b = '0;

    // idle state: all-zero word is no branch, PC steps by 4 (R1, R7)
    apply(32'h0, 32'h0000_0100, 32'd0, 32'd0);
    chk("R1 idle flag", {31'd0, is_branch}, 32'd0);
    chk("R7 idle next", next_pc, 32'h0000_0104);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [31:0] p;
      p = 32'h0000_1000 + 32'(i) * 32'h40;
      apply(mk_b(VT[i].f3, VT[i].off), p, VT[i].a, VT[i].b);
      chk("R1 flag", {31'd0, is_branch}, 32'd1);
      chk(VT[i].f3[2] ? (VT[i].f3[1] ? "R4 R5 cond" : "R3 R5 cond") : "R2 R5 cond",
          alu_res, {31'd0, VT[i].tk});
      chk(VT[i].tk ? "R6 target" : "R7 fallthrough", next_pc,
          VT[i].tk ? p + sext13(VT[i].off) : p + 32'd4);
    end

    // reserved conditions 010/011 with equal operands: no redirect (R1, R7)
    for (int c = 2; c < 4; c++) begin
      apply(mk_b(3'(c), 13'h0040), 32'h0000_2000, 32'd9, 32'd9);
      chk("R1 reserved flag", {31'd0, is_branch}, 32'd0);
      chk("R7 reserved next", next_pc, 32'h0000_2004);
    end

    // non-branch opcode, odd sum: ALU adds, PC still steps by 4 (R8)
    apply(32'h0020_80B3, 32'h0000_3000, 32'd2, 32'd3);
    chk("R8 add result", alu_res, 32'd5);
    chk("R8 no redirect", next_pc, 32'h0000_3004);
    chk("R1 other opcode", {31'd0, is_branch}, 32'd0);

    // backward branch wrapping below zero (R6)
    apply(mk_b(3'b000, 13'h1FFC), 32'h0000_0000, 32'd1, 32'd1);
    chk("R6 wrap target", next_pc, 32'hFFFF_FFFC);

    // most negative offset (R6)
    apply(mk_b(3'b001, 13'h1000), 32'h0001_0000, 32'd1, 32'd2);
    chk("R6 min offset", next_pc, 32'h0000_F000);

    // sequential wrap at top of address space (R7)
    apply(mk_b(3'b000, 13'h0010), 32'hFFFF_FFFC, 32'd1, 32'd2);
    chk("R7 wrap next", next_pc, 32'h0000_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule